// File: doc/BRIEF.md
# Three-Wire Serial Memory Slave

This block is the slave side of a small serial non-volatile memory. A host drives chip select, a serial clock and a data-in line; the block answers on a data-out line with a separate output enable, so the pad (or a shared data line) can be driven only when the block has something to say. The storage is modelled by an internal register file of 128 bytes. An organization input chooses whether that storage is seen as 128 eight-bit words or 64 sixteen-bit words.

All logic runs on a free-running system clock. The serial clock is an ordinary input whose rising edges are detected against a registered copy, so a rising edge takes effect at the next system clock edge. While chip select is high, the block waits for a start bit, then gathers a two-bit opcode, an address and, where needed, a data word, all most significant bit first. Read instructions stream data back after a single zero bit and keep going through successive addresses. Program instructions (write, erase, erase-all, write-all) are passed to a self-timed program sequencer. Data-out also reports ready/busy while a program cycle runs.

The serial pins have no back-pressure. Inside the block, the front end offers each decoded program instruction to the sequencer through a one-cycle valid pulse against a ready signal. Ready is low while a program cycle runs, and an offer made then is discarded, not held.

Top module: `mwire_mem_slave`

## Requirements
- R1: After reset and whenever chip select is low, the data-out enable is low. It drops in the same system cycle that chip select falls, including in the middle of a read.
- R2: With chip select high, serial clock rising edges that sample data-in low before the first sampled high cause no operation. The first rising edge with data-in high is the start bit.
- R3: After the last address bit of a read (opcode 10), data-out is enabled and shows a zero. Each following serial clock rising edge then shows one data bit, most significant bit first.
- R4: Continued clocking during a read outputs the next word each time a word ends. The address wraps from the last word of the current organization to word 0.
- R5: With organization input high, addresses are 6 bits and words are 16 bits. Word w occupies bytes 2w (upper half) and 2w+1 (lower half). With the input low, addresses are 7 bits and words are 8 bits.
- R6: After reset, write, erase, erase-all and write-all have no effect until an enable instruction runs (opcode 00, top two address bits 11). A disable instruction (opcode 00, top bits 00) blocks them again.
- R7: A program instruction takes effect only after its full bit count has arrived: 2 opcode bits, the address, and the data word for write (opcode 01) and write-all (opcode 00, top address bits 01). If chip select falls earlier, nothing changes.
- R8: Erase (opcode 11) sets the addressed word to all ones.
- R9: Erase-all (opcode 00, top address bits 10) sets every byte to all ones. Write-all writes the given word into every word of the current organization.
- R10: While a program cycle runs, raising chip select before a start bit enables data-out showing 0. Once the cycle ends, it shows 1. The next start bit ends the status display.
- R11: A program instruction that completes while an earlier program cycle is still running is discarded.
- R12: After an instruction has completed, further serial clocks and data-in values are ignored until chip select falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sck | input | 1 | Serial clock, sampled on clk |
| di | input | 1 | Serial data in |
| org | input | 1 | Organization: 1 = 64 x 16, 0 = 128 x 8 |
| do_data | output | 1 | Serial data out value |
| do_oe | output | 1 | Output enable for do_data (low means high impedance) |

## Verification
The bench builds the block with a program time of 400 system cycles. That is long enough for a complete second 25-bit instruction to arrive while the first cycle is still busy, so the discard rule and the busy-then-ready status both become observable. The default 128-byte geometry is kept, so the bench reaches wrap-around at both organizations (byte 127 to byte 0, word 63 to word 0). It also shows how the two organizations overlay the same bytes, by writing in one organization and reading in the other.

// File: rtl/mwire_pkg.sv
`timescale 1ns/1ps
package mwire_pkg;
  localparam int unsigned MEM_BYTES = 128;
  localparam int unsigned AW_NARROW = $clog2(MEM_BYTES);
  localparam int unsigned AW_WIDE   = AW_NARROW - 1;
  localparam int unsigned DW_NARROW = 8;
  localparam int unsigned DW_WIDE   = 2 * DW_NARROW;
  localparam int unsigned FRAME_N   = 2 + AW_NARROW + DW_NARROW;
  localparam int unsigned FRAME_W   = 2 + AW_WIDE + DW_WIDE;
  localparam int unsigned FRAME_MAX = (FRAME_N > FRAME_W) ? FRAME_N : FRAME_W;
  localparam int unsigned CNT_W     = $clog2(FRAME_MAX + 1);
  localparam int unsigned LEFT_W    = $clog2(DW_WIDE + 1);

  typedef logic [1:0] opc_t;
  localparam opc_t OPC_SPECIAL = 2'b00;
  localparam opc_t OPC_WRITE   = 2'b01;
  localparam opc_t OPC_READ    = 2'b10;
  localparam opc_t OPC_ERASE   = 2'b11;

  localparam logic [1:0] SUB_UNLOCK = 2'b11;
  localparam logic [1:0] SUB_LOCK   = 2'b00;
  localparam logic [1:0] SUB_CLRALL = 2'b10;
  localparam logic [1:0] SUB_SETALL = 2'b01;

  typedef enum logic [2:0] {
    K_WRITE, K_ERASE, K_CLRALL, K_SETALL, K_UNLOCK, K_LOCK
  } pgm_kind_e;

  typedef struct packed {
    pgm_kind_e              kind;
    logic                   wide;
    logic [AW_NARROW-1:0]   addr;
    logic [DW_WIDE-1:0]     data;
  } pgm_cmd_t;
endpackage

// File: rtl/mwire_store.sv
`timescale 1ns/1ps
module mwire_store
  import mwire_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 wr_all,
  input  logic                 wr_wide,
  input  logic [AW_NARROW-1:0] wr_addr,
  input  logic [DW_WIDE-1:0]   wr_data,
  input  logic [AW_NARROW-1:0] rd_addr,
  input  logic                 rd_wide,
  output logic [DW_WIDE-1:0]   rd_word
);
  logic [DW_NARROW-1:0] mem [MEM_BYTES];
  logic [MEM_BYTES-1:0] hit;

  for (genvar i = 0; i < MEM_BYTES; i++) begin : g_sel
    localparam logic [AW_NARROW-1:0] IDX = AW_NARROW'(i);
    assign hit[i] = wr_all |
                    ( wr_wide & (wr_addr[AW_WIDE-1:0] == IDX[AW_NARROW-1:1])) |
                    (!wr_wide & (wr_addr == IDX));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= '1;
    end else if (wr_en) begin
      for (int i = 0; i < MEM_BYTES; i++) begin
        if (hit[i]) begin
          if (wr_wide && (i % 2 == 0)) mem[i] <= wr_data[DW_WIDE-1:DW_NARROW];
          else                         mem[i] <= wr_data[DW_NARROW-1:0];
        end
      end
    end
  end

  logic [AW_NARROW-1:0] hi_idx, lo_idx;
  assign hi_idx = {rd_addr[AW_WIDE-1:0], 1'b0};
  assign lo_idx = {rd_addr[AW_WIDE-1:0], 1'b1};

  always_comb begin
    if (rd_wide) rd_word = {mem[hi_idx], mem[lo_idx]};
    else         rd_word = {mem[rd_addr], {DW_NARROW{1'b0}}};
  end
endmodule

// File: rtl/mwire_prog_seq.sv
`timescale 1ns/1ps
module mwire_prog_seq
  import mwire_pkg::*;
#(
  parameter int unsigned PROG_CYCLES = 2000
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  pgm_cmd_t             cmd,
  output logic                 busy,
  output logic                 wr_en,
  output logic                 wr_all,
  output logic                 wr_wide,
  output logic [AW_NARROW-1:0] wr_addr,
  output logic [DW_WIDE-1:0]   wr_data
);
  localparam int unsigned CYC_W = $clog2(PROG_CYCLES + 1);

  logic             unlocked;
  logic [CYC_W-1:0] cyc;
  pgm_cmd_t         job;
  logic             take;

  assign cmd_ready = ~busy;
  assign take      = cmd_valid & cmd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
      busy     <= 1'b0;
      cyc      <= '0;
      job      <= '0;
    end else if (take) begin
      case (cmd.kind)
        K_UNLOCK: unlocked <= 1'b1;
        K_LOCK:   unlocked <= 1'b0;
        default: begin
          if (unlocked) begin
            busy <= 1'b1;
            cyc  <= CYC_W'(PROG_CYCLES - 1);
            job  <= cmd;
          end
        end
      endcase
    end else if (busy) begin
      if (cyc == '0) busy <= 1'b0;
      else           cyc  <= cyc - 1'b1;
    end
  end

  assign wr_en   = busy & (cyc == '0);
  assign wr_all  = (job.kind == K_CLRALL) | (job.kind == K_SETALL);
  assign wr_wide = job.wide;
  assign wr_addr = job.addr;
  assign wr_data = ((job.kind == K_ERASE) | (job.kind == K_CLRALL)) ? '1 : job.data;

  // R6: a program cycle only ever starts while unlocked
  p_locked_no_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$past(busy)) |-> unlocked);

  // R10: busy is held until the countdown has expired
  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cyc != '0) |=> busy);

  // R11: an offer made while busy does not restart the countdown
  p_busy_no_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid && cyc != '0) |=> (cyc == $past(cyc) - 1'b1));
endmodule

// File: rtl/mwire_front.sv
`timescale 1ns/1ps
module mwire_front
  import mwire_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs,
  input  logic                 sck,
  input  logic                 di,
  input  logic                 org,
  input  logic                 prog_busy,
  output logic                 cmd_valid,
  output pgm_cmd_t             cmd,
  output logic [AW_NARROW-1:0] rd_addr,
  output logic                 rd_wide,
  input  logic [DW_WIDE-1:0]   rd_word,
  output logic                 do_data,
  output logic                 do_oe
);
  typedef enum logic [1:0] {ST_HUNT, ST_SHIFT, ST_READ, ST_DONE} st_e;

  st_e                  state;
  logic                 sck_q;
  logic                 sck_rise;
  logic [FRAME_MAX-2:0] sr;
  logic [FRAME_MAX-1:0] cur;
  logic [CNT_W-1:0]     cnt, nbits, hdr_len, full_len;
  logic [DW_WIDE-1:0]   rd_sh;
  logic [LEFT_W-1:0]    rd_left, dw_m1;
  logic [AW_NARROW-1:0] rd_next, addr_mask;
  logic                 dout, stat_pend, start_seen;

  logic                 h_needs;
  opc_t                 h_op, f_op;
  logic [1:0]           h_sub;
  logic [AW_NARROW-1:0] h_addr, f_addr;
  logic [DW_WIDE-1:0]   f_data;
  pgm_kind_e            h_kind;

  assign sck_rise   = cs & sck & ~sck_q;
  assign start_seen = sck_rise & di & (state == ST_HUNT);
  assign cur        = {sr, di};
  assign nbits      = cnt + 1'b1;
  assign hdr_len    = org ? CNT_W'(2 + AW_WIDE) : CNT_W'(2 + AW_NARROW);
  assign full_len   = org ? CNT_W'(FRAME_W)     : CNT_W'(FRAME_N);
  assign dw_m1      = org ? LEFT_W'(DW_WIDE - 1) : LEFT_W'(DW_NARROW - 1);
  assign addr_mask  = org ? {1'b0, {AW_WIDE{1'b1}}} : {AW_NARROW{1'b1}};
  assign rd_next    = (rd_addr + 1'b1) & addr_mask;
  assign rd_wide    = org;

  // field extraction at header completion and at frame completion
  always_comb begin
    if (org) begin
      h_op   = cur[AW_WIDE+1 -: 2];
      h_addr = {1'b0, cur[AW_WIDE-1:0]};
      h_sub  = cur[AW_WIDE-1 -: 2];
      f_op   = cur[AW_WIDE+DW_WIDE+1 -: 2];
      f_addr = {1'b0, cur[AW_WIDE+DW_WIDE-1 -: AW_WIDE]};
      f_data = cur[DW_WIDE-1:0];
    end else begin
      h_op   = cur[AW_NARROW+1 -: 2];
      h_addr = cur[AW_NARROW-1:0];
      h_sub  = cur[AW_NARROW-1 -: 2];
      f_op   = cur[AW_NARROW+DW_NARROW+1 -: 2];
      f_addr = cur[AW_NARROW+DW_NARROW-1 -: AW_NARROW];
      f_data = {{DW_NARROW{1'b0}}, cur[DW_NARROW-1:0]};
    end
  end

  always_comb begin
    h_needs = (h_op == OPC_WRITE) | ((h_op == OPC_SPECIAL) & (h_sub == SUB_SETALL));
    h_kind  = K_ERASE;
    if (h_op == OPC_SPECIAL) begin
      case (h_sub)
        SUB_UNLOCK: h_kind = K_UNLOCK;
        SUB_LOCK:   h_kind = K_LOCK;
        SUB_CLRALL: h_kind = K_CLRALL;
        default:    h_kind = K_SETALL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q     <= 1'b0;
      state     <= ST_HUNT;
      sr        <= '0;
      cnt       <= '0;
      cmd_valid <= 1'b0;
      cmd       <= '0;
      rd_addr   <= '0;
      rd_sh     <= '0;
      rd_left   <= '0;
      dout      <= 1'b0;
    end else begin
      sck_q     <= sck;
      cmd_valid <= 1'b0;
      if (!cs) begin
        state <= ST_HUNT;
      end else if (sck_rise) begin
        case (state)
          ST_HUNT: begin
            if (di) begin
              state <= ST_SHIFT;
              cnt   <= '0;
              sr    <= '0;
            end
          end
          ST_SHIFT: begin
            sr  <= cur[FRAME_MAX-2:0];
            cnt <= nbits;
            if (nbits == hdr_len) begin
              if (h_op == OPC_READ) begin
                state   <= ST_READ;
                dout    <= 1'b0;
                rd_addr <= h_addr;
                rd_left <= '0;
              end else if (!h_needs) begin
                state     <= ST_DONE;
                cmd_valid <= 1'b1;
                cmd       <= '{kind: h_kind, wide: org, addr: h_addr, data: '0};
              end
            end else if (nbits == full_len) begin
              state     <= ST_DONE;
              cmd_valid <= 1'b1;
              cmd       <= '{kind: (f_op == OPC_WRITE) ? K_WRITE : K_SETALL,
                             wide: org, addr: f_addr, data: f_data};
            end
          end
          ST_READ: begin
            if (rd_left == '0) begin
              dout    <= rd_word[DW_WIDE-1];
              rd_sh   <= rd_word << 1;
              rd_left <= dw_m1;
            end else begin
              dout    <= rd_sh[DW_WIDE-1];
              rd_sh   <= rd_sh << 1;
              rd_left <= rd_left - 1'b1;
              if (rd_left == LEFT_W'(1)) rd_addr <= rd_next;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // ready/busy status bookkeeping for the pre-start window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               stat_pend <= 1'b0;
    else if (start_seen)      stat_pend <= 1'b0;
    else if (prog_busy)       stat_pend <= 1'b1;
    else if (!cs)             stat_pend <= 1'b0;
  end

  assign do_oe   = cs & ((state == ST_READ) | ((state == ST_HUNT) & stat_pend));
  assign do_data = (state == ST_READ) ? dout : ~prog_busy;

  // R3: the first cycle of a read shows the leading zero
  p_dummy_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_READ && $past(state) != ST_READ) |-> (dout == 1'b0));

  // R7: the bit counter never runs past the longest frame
  p_frame_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SHIFT) |-> (cnt < CNT_W'(FRAME_MAX)));

  // R12: an issued instruction always leaves the front end parked
  p_cmd_parks_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (state == ST_DONE));

  // R1: no drive on data-out while deselected
  p_quiet_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs && $past(!cs)) |-> !do_oe);
endmodule

// File: rtl/mwire_mem_slave.sv
`timescale 1ns/1ps
module mwire_mem_slave
  import mwire_pkg::*;
#(
  parameter int unsigned PROG_CYCLES = 2000
)(
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sck,
  input  logic di,
  input  logic org,
  output logic do_data,
  output logic do_oe
);
  logic                 cmd_valid, cmd_ready, busy;
  pgm_cmd_t             cmd;
  logic                 wr_en, wr_all, wr_wide;
  logic [AW_NARROW-1:0] wr_addr, rd_addr;
  logic [DW_WIDE-1:0]   wr_data, rd_word;
  logic                 rd_wide;

  mwire_front u_front (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sck(sck), .di(di), .org(org),
    .prog_busy(busy), .cmd_valid(cmd_valid), .cmd(cmd),
    .rd_addr(rd_addr), .rd_wide(rd_wide), .rd_word(rd_word),
    .do_data(do_data), .do_oe(do_oe)
  );

  mwire_prog_seq #(.PROG_CYCLES(PROG_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd(cmd), .busy(busy), .wr_en(wr_en), .wr_all(wr_all),
    .wr_wide(wr_wide), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  mwire_store u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_all(wr_all),
    .wr_wide(wr_wide), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_wide(rd_wide), .rd_word(rd_word)
  );

  // R11: ready is withdrawn for the whole program cycle
  p_ready_vs_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);
endmodule

// File: tb/mwire_mem_slave_test.sv
`timescale 1ns/1ps
module mwire_mem_slave_test;
  localparam int PROG = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sck = 1'b0, di = 1'b0, org = 1'b1;
  logic do_data, do_oe;
  int   checks = 0, fails = 0;
  logic last_o, last_oe;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  mwire_mem_slave #(.PROG_CYCLES(PROG)) uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sck(sck), .di(di), .org(org),
    .do_data(do_data), .do_oe(do_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sbit(input logic b);
    @(negedge clk); di = b; sck = 1'b0;
    repeat (2) @(negedge clk);
    sck = 1'b1;
    repeat (2) @(negedge clk);
    last_o = do_data; last_oe = do_oe;
  endtask

  task automatic deselect();
    @(negedge clk); cs = 1'b0; sck = 1'b0; di = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic header(input logic wide, input logic [1:0] op, input logic [6:0] addr);
    @(negedge clk); org = wide; cs = 1'b1;
    sbit(1'b1);
    sbit(op[1]); sbit(op[0]);
    for (int k = (wide ? 5 : 6); k >= 0; k--) sbit(addr[k]);
  endtask

  task automatic send_data(input logic wide, input logic [15:0] d, input int nb);
    for (int k = (wide ? 15 : 7); k >= 0 && nb > 0; k--) begin
      sbit(d[k]); nb--;
    end
  endtask

  task automatic write_word(input logic wide, input logic [6:0] a, input logic [15:0] d, input bit settle);
    header(wide, 2'b01, a); send_data(wide, d, 16); deselect();
    if (settle) repeat (PROG + 50) @(negedge clk);
  endtask

  task automatic special(input logic [1:0] sub, input logic [15:0] d, input bit settle);
    header(1'b1, 2'b00, {1'b0, sub, 4'b0000});
    if (sub == 2'b01) send_data(1'b1, d, 16);
    deselect();
    if (settle) repeat (PROG + 50) @(negedge clk);
  endtask

  task automatic read_check(input logic wide, input logic [6:0] a, input int n,
                            input logic [15:0] e0, input logic [15:0] e1, input string req);
    logic [15:0] w;
    header(wide, 2'b10, a);
    chk({req, " dummy zero oe (R3)"}, last_oe, 1'b1);
    chk({req, " dummy zero (R3)"}, last_o, 1'b0);
    for (int i = 0; i < n; i++) begin
      w = '0;
      for (int k = 0; k < (wide ? 16 : 8); k++) begin
        sbit(1'b0);
        w = {w[14:0], last_o};
      end
      chk(req, w, (i == 0) ? e0 : e1);
    end
    deselect();
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 oe after reset", do_oe, 1'b0);
    cs = 1'b1; org = 1'b1;
    for (int i = 0; i < 3; i++) sbit(1'b0);
    chk("R2 no drive before start", last_oe, 1'b0);
    sbit(1'b1); sbit(1'b1); sbit(1'b0);
    for (int k = 0; k < 6; k++) sbit(1'b0);
    chk("R2 start after zeros gives read dummy", {last_oe, last_o}, 2'b10);
    for (int k = 0; k < 4; k++) sbit(1'b0);
    chk("R3 read bits of erased word", last_o, 1'b1);
    @(negedge clk); cs = 1'b0; #1;
    chk("R1 oe drops with cs mid-read", do_oe, 1'b0);
    deselect();
  endtask

  task automatic t_locked();
    write_word(1'b1, 7'd5, 16'h1234, 1'b0);
    @(negedge clk); cs = 1'b1; @(negedge clk);
    chk("R6 no busy when locked", do_oe, 1'b0);
    deselect();
    read_check(1'b1, 7'd5, 1, 16'hFFFF, 16'h0, "R6 locked write ignored");
  endtask

  task automatic t_write_status();
    special(2'b11, 16'h0, 1'b0);
    write_word(1'b1, 7'd5, 16'h1234, 1'b0);
    @(negedge clk); cs = 1'b1; @(negedge clk);
    chk("R10 busy status", {do_oe, do_data}, 2'b10);
    repeat (PROG + 50) @(negedge clk);
    chk("R10 ready status", {do_oe, do_data}, 2'b11);
    deselect();
    read_check(1'b1, 7'd5, 1, 16'h1234, 16'h0, "R5 wide write/read");
  endtask

  task automatic t_narrow();
    read_check(1'b0, 7'd10, 2, 16'h0012, 16'h0034, "R5 narrow view of wide word (R4 sequential)");
    write_word(1'b0, 7'd127, 16'h00A5, 1'b1);
    read_check(1'b0, 7'd127, 2, 16'h00A5, 16'h00FF, "R4 narrow wrap");
    read_check(1'b1, 7'd63, 2, 16'hFFA5, 16'hFFFF, "R4 wide wrap");
  endtask

  task automatic t_erase();
    header(1'b1, 2'b11, 7'd5); deselect();
    repeat (PROG + 50) @(negedge clk);
    read_check(1'b1, 7'd5, 1, 16'hFFFF, 16'h0, "R8 erase");
  endtask

  task automatic t_partial();
    header(1'b1, 2'b01, 7'd2); send_data(1'b1, 16'h0000, 10); deselect();
    @(negedge clk); cs = 1'b1; @(negedge clk);
    chk("R7 short frame starts no cycle", do_oe, 1'b0);
    deselect();
    repeat (PROG + 50) @(negedge clk);
    read_check(1'b1, 7'd2, 1, 16'hFFFF, 16'h0, "R7 short frame no write");
  endtask

  task automatic t_overlap();
    write_word(1'b1, 7'd3, 16'hAAAA, 1'b0);
    write_word(1'b1, 7'd4, 16'h5555, 1'b1);
    read_check(1'b1, 7'd3, 1, 16'hAAAA, 16'h0, "R11 first write kept");
    read_check(1'b1, 7'd4, 1, 16'hFFFF, 16'h0, "R11 overlapping write dropped");
  endtask

  task automatic t_trailing();
    header(1'b1, 2'b00, 7'b0110000);
    sbit(1'b1); sbit(1'b0); sbit(1'b1);
    for (int k = 5; k >= 0; k--) sbit(k == 1);
    send_data(1'b1, 16'h0F0F, 16);
    deselect();
    repeat (PROG + 50) @(negedge clk);
    read_check(1'b1, 7'd2, 1, 16'hFFFF, 16'h0, "R12 trailing bits ignored");
  endtask

  task automatic t_all();
    special(2'b01, 16'h5AC3, 1'b1);
    read_check(1'b1, 7'd0, 2, 16'h5AC3, 16'h5AC3, "R9 write-all");
    read_check(1'b1, 7'd63, 1, 16'h5AC3, 16'h0, "R9 write-all top");
    special(2'b10, 16'h0, 1'b1);
    read_check(1'b1, 7'd7, 1, 16'hFFFF, 16'h0, "R9 erase-all");
    special(2'b00, 16'h0, 1'b0);
    write_word(1'b1, 7'd1, 16'h1111, 1'b1);
    read_check(1'b1, 7'd1, 1, 16'hFFFF, 16'h0, "R6 relocked write ignored");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_locked();
    t_write_status();
    t_narrow();
    t_erase();
    t_partial();
    t_overlap();
    t_trailing();
    t_all();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule